// File: doc/BRIEF.md
# Character-Synchronous Serial Transmitter with Automatic Fill

This block serialises 8-bit characters onto a single data line, one bit per tick of a bit-clock enable, most significant bit first. A CPU (or a DMA engine) places the next character into a one-entry holding buffer. The shifter takes it from there at the end of each character slot. When the holding buffer has run dry at a slot boundary, the transmitter does not stall. It inserts filler on its own, and an end-of-message latch picks the kind of filler. With the latch set, the filler is the programmable sync character. With the latch cleared, the filler is the 16-bit check sum of the message so far, after which sync characters follow and the latch sets again.

Software learns of each buffer transfer from the buffer-empty flag, a pending transmit interrupt, or a DMA request line. A one-cycle status interrupt marks each underrun. Three command strobes are available: clear the pending transmit interrupt, clear the end-of-message latch, and preset the check-sum accumulator. When transmit enable is removed, the slot in flight finishes and the line then rests at one. The exception is a check-sum slot: its unsent bits are overwritten with sync pattern bits so that the 16-bit slot still ends cleanly.

Top module: `sync_tx`

## Requirements
- R1: After reset, txd is 1, buf_empty is 1, eom_latch is 1, tx_irq is 0, ext_irq is 0 and tx_rdy is 0.
- R2: Each character slot shifts its bits out MSB-first, one bit for each cycle in which bit_en is high. A slot starts on the bit_en tick that ends the previous slot, or, from rest, on the first bit_en tick that sees tx_en high. At rest the line is 1.
- R3: buf_empty clears on the cycle after a wr_en write and sets again when the buffer moves into the shifter. tx_rdy is high exactly when tx_en is high and buf_empty reads 1.
- R4: Every transfer from the buffer into the shifter sets tx_irq. A cmd_rst_txip strobe or a buffer write clears it.
- R5: When the shifter finishes a data character with the buffer empty and eom_latch at 1, sync characters follow. tx_irq sets when the first of them loads, and ext_irq pulses for one cycle at the same moment.
- R6: cmd_rst_eom clears eom_latch. At the next underrun the shifter sends the 16-bit check sum, eom_latch returns to 1 as that slot loads, ext_irq pulses, and a sync character follows the check sum.
- R7: buf_empty reads 0 while the check-sum slot is shifting. When the first sync character after it loads, buf_empty returns to 1 and tx_irq sets.
- R8: The check sum uses polynomial x^16+x^12+x^5+1, is preset to all ones by reset or cmd_rst_crc, and takes in the bits MSB-first of data characters that loaded while crc_en was high. Sync and check-sum bits are not included.
- R9: If tx_en falls during a data or sync slot, that slot completes and the line then stays at 1. A character written to the buffer while the line is disabled stays there, and buf_empty stays 0.
- R10: If tx_en falls during the check-sum slot, the slot still runs its 16 bits. Each bit from that point on is sync_char[7 - (i mod 8)], where i is the bit index 0..15 in the slot. The line then stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Bit-clock enable, one shift per high cycle |
| tx_en | input | 1 | Transmitter enable |
| crc_en | input | 1 | Include the next loaded data character in the check sum |
| sync_char | input | 8 | Programmable sync pattern |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Character to write |
| cmd_rst_txip | input | 1 | Clear the pending transmit interrupt |
| cmd_rst_eom | input | 1 | Clear the end-of-message latch |
| cmd_rst_crc | input | 1 | Preset the check-sum accumulator |
| txd | output | 1 | Serial data line |
| buf_empty | output | 1 | Holding buffer empty status |
| eom_latch | output | 1 | End-of-message latch status |
| tx_irq | output | 1 | Pending transmit interrupt |
| ext_irq | output | 1 | One-cycle underrun status interrupt |
| tx_rdy | output | 1 | DMA request for the next character |

## Verification
Each slot boundary falls on a bit_en edge. The new bit shows on txd from that edge on, so the bench samples txd on the falling clock edge just before each bit_en edge. The status outputs are registered. buf_empty, tx_irq and eom_latch therefore move one cycle after the write, strobe or load edge that causes them, and ext_irq is high for exactly that one cycle. The bench waits for these edges on the falling clock and checks the related flags in the same sample. It starts each message on a bit_en cycle, so the expected bit queue lines up with the first shifted bit. Each disable is timed by how many expected bits are still in the queue.

// File: rtl/sync_tx_pkg.sv
// Package: shared slot type for the synchronous transmitter.
// Assumes: one shifter slot is either resting, data, sync or check sum.
package sync_tx_pkg;
    typedef enum logic [1:0] {
        SL_IDLE = 2'd0,
        SL_DATA = 2'd1,
        SL_SYNC = 2'd2,
        SL_CRC  = 2'd3
    } slot_e;
endpackage

// File: rtl/sync_tx_crc.sv
// Serial check-sum accumulator, MSB-first, one bit per update.
// Assumes: clr has priority over upd; crc_next shows the value after this cycle.
module sync_tx_crc #(
    parameter int          W    = 16,
    parameter logic [15:0] POLY = 16'h1021,
    parameter logic [15:0] INIT = 16'hFFFF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         upd,
    input  logic         bit_in,
    output logic [W-1:0] crc_next
);
    logic [W-1:0] crc_q;
    logic         fb;

    // Next value: shift with feedback when a bit is taken in.
    always_comb begin
        fb       = crc_q[W-1] ^ bit_in;
        crc_next = crc_q;
        if (upd)
            crc_next = {crc_q[W-2:0], 1'b0} ^ (fb ? POLY[W-1:0] : '0);
    end

    // Register: preset on reset or clear, otherwise follow crc_next.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) crc_q <= INIT[W-1:0];
        else               crc_q <= crc_next;
    end

    assert_clr_preset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> crc_q == INIT[W-1:0]);
endmodule

// File: rtl/sync_tx_shifter.sv
// Output shifter: holds one slot (8-bit char or 16-bit check sum), shifts MSB-first.
// Assumes: load is asserted only on a bit_en cycle; while disabled inside a check-sum
// slot the remaining bits come from the sync pattern at the same bit position.
module sync_tx_shifter
    import sync_tx_pkg::*;
#(
    parameter int CHAR_W = 8,
    parameter int CRC_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              tx_en,
    input  logic              load,
    input  slot_e             load_slot,
    input  logic [CRC_W-1:0]  load_val,
    input  logic [CHAR_W-1:0] sync_char,
    output slot_e             slot,
    output logic              last_bit,
    output logic              cur_bit,
    output logic              txd
);
    localparam int CNT_W = $clog2(CRC_W);
    localparam int IDX_W = $clog2(CHAR_W);

    logic [CRC_W-1:0] sreg;
    logic [CNT_W-1:0] cnt;
    logic             abort_q;
    logic [IDX_W-1:0] idx;

    // Slot end detection: the final bit of the current slot is on the line.
    always_comb begin
        if (slot == SL_CRC) last_bit = (cnt == CNT_W'(CRC_W - 1));
        else                last_bit = (cnt == CNT_W'(CHAR_W - 1));
    end

    assign idx     = cnt[IDX_W-1:0];
    assign cur_bit = sreg[CRC_W-1];

    // Line driver: rest high, else shifter MSB, or sync bits once a check-sum slot is cut.
    always_comb begin
        if (slot == SL_IDLE)                               txd = 1'b1;
        else if (slot == SL_CRC && (abort_q || !tx_en))    txd = sync_char[IDX_W'(CHAR_W - 1) - idx];
        else                                               txd = sreg[CRC_W-1];
    end

    // Slot state: load a new slot, or shift one bit per enable tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot    <= SL_IDLE;
            sreg    <= '1;
            cnt     <= '0;
            abort_q <= 1'b0;
        end else if (load) begin
            slot    <= load_slot;
            sreg    <= load_val;
            cnt     <= '0;
            abort_q <= 1'b0;
        end else begin
            if (slot == SL_CRC && !tx_en) abort_q <= 1'b1;
            if (bit_en && slot != SL_IDLE) begin
                sreg <= {sreg[CRC_W-2:0], 1'b1};
                cnt  <= cnt + 1'b1;
            end
        end
    end

    assert_char_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (slot != SL_CRC) |-> (cnt < CNT_W'(CHAR_W)));
    assert_load_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> bit_en);
endmodule

// File: rtl/sync_tx.sv
// Top: holding buffer, end-of-message latch, interrupts and slot selection.
// Assumes: bit_en is a single-cycle tick; commands are single-cycle strobes; a write
// in the same cycle as a transfer refills the buffer with the new character.
module sync_tx
    import sync_tx_pkg::*;
#(
    parameter int          CHAR_W   = 8,
    parameter int          CRC_W    = 16,
    parameter logic [15:0] CRC_POLY = 16'h1021,
    parameter logic [15:0] CRC_INIT = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              tx_en,
    input  logic              crc_en,
    input  logic [CHAR_W-1:0] sync_char,
    input  logic              wr_en,
    input  logic [CHAR_W-1:0] wr_data,
    input  logic              cmd_rst_txip,
    input  logic              cmd_rst_eom,
    input  logic              cmd_rst_crc,
    output logic              txd,
    output logic              buf_empty,
    output logic              eom_latch,
    output logic              tx_irq,
    output logic              ext_irq,
    output logic              tx_rdy
);
    localparam int PAD_W = CRC_W - CHAR_W;

    logic [CHAR_W-1:0] buf_q;
    logic              buf_full;
    logic              crc_flag;
    slot_e             slot;
    slot_e             nxt;
    logic              last_bit, cur_bit, load;
    logic              take_data, underrun, after_crc;
    logic [CRC_W-1:0]  load_val;
    logic [CRC_W-1:0]  crc_next;

    // Slot boundary: a tick ends the current slot, or starts one from rest.
    assign load = bit_en && ((slot == SL_IDLE) ? tx_en : last_bit);

    // Next slot choice and the events it produces.
    always_comb begin
        underrun  = 1'b0;
        after_crc = 1'b0;
        take_data = 1'b0;
        nxt       = SL_IDLE;
        load_val  = {sync_char, {PAD_W{1'b1}}};
        if (tx_en) begin
            if (slot == SL_CRC) begin
                after_crc = 1'b1;
                nxt       = SL_SYNC;
            end else if (buf_full) begin
                take_data = 1'b1;
                nxt       = SL_DATA;
                load_val  = {buf_q, {PAD_W{1'b1}}};
            end else begin
                underrun = (slot == SL_DATA);
                nxt      = (underrun && !eom_latch) ? SL_CRC : SL_SYNC;
                if (nxt == SL_CRC) load_val = crc_next;
            end
        end
    end

    // Holding buffer and the check-sum include flag of the character in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q    <= '0;
            buf_full <= 1'b0;
            crc_flag <= 1'b0;
        end else begin
            if (load && take_data) begin
                buf_full <= 1'b0;
                crc_flag <= crc_en;
            end
            if (wr_en) begin
                buf_q    <= wr_data;
                buf_full <= 1'b1;
            end
        end
    end

    // End-of-message latch: cleared by command, set again at a check-sum underrun.
    always_ff @(posedge clk) begin
        if (!rst_n)                              eom_latch <= 1'b1;
        else if (load && underrun && !eom_latch) eom_latch <= 1'b1;
        else if (cmd_rst_eom)                    eom_latch <= 1'b0;
    end

    // Interrupts: pending transmit flag and one-cycle underrun pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_irq  <= 1'b0;
            ext_irq <= 1'b0;
        end else begin
            ext_irq <= load && underrun;
            if (load && (take_data || after_crc || (underrun && eom_latch)))
                tx_irq <= 1'b1;
            else if (cmd_rst_txip || wr_en)
                tx_irq <= 1'b0;
        end
    end

    assign buf_empty = !buf_full && (slot != SL_CRC);
    assign tx_rdy    = tx_en && buf_empty;

    sync_tx_crc #(.W(CRC_W), .POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cmd_rst_crc),
        .upd      (bit_en && slot == SL_DATA && crc_flag),
        .bit_in   (cur_bit),
        .crc_next (crc_next)
    );

    sync_tx_shifter #(.CHAR_W(CHAR_W), .CRC_W(CRC_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .tx_en     (tx_en),
        .load      (load),
        .load_slot (nxt),
        .load_val  (load_val),
        .sync_char (sync_char),
        .slot      (slot),
        .last_bit  (last_bit),
        .cur_bit   (cur_bit),
        .txd       (txd)
    );

    assert_write_fills_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !buf_empty);
    assert_txip_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rst_txip && !load) |=> !tx_irq);
    assert_crc_needs_open_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && nxt == SL_CRC) |-> (!eom_latch && slot == SL_DATA));
    assert_ext_leaves_latch_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ext_irq |-> eom_latch);
endmodule

// File: tb/sim_sync_tx.sv
module sim_sync_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       tx_en = 1'b0;
    logic       crc_en = 1'b0;
    logic [7:0] sync_char = 8'h16;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       cmd_rst_txip = 1'b0;
    logic       cmd_rst_eom = 1'b0;
    logic       cmd_rst_crc = 1'b0;
    logic       txd, buf_empty, eom_latch, tx_irq, ext_irq, tx_rdy;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    logic [1:0] div = '0;
    bit  exp_q[$];
    int  tag_q[$];

    sync_tx u0 (.*);

    always #2 clk = ~clk;

    // Bit-clock tick: one cycle in four, driven 1 ns after the edge.
    always @(posedge clk) begin
        #1;
        div    = div + 2'd1;
        bit_en = (div == 2'd3) && rst_n;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: compare each bit on the line just before its shift edge.
    always @(negedge clk) begin
        if (bit_en && exp_q.size() > 0) begin
            automatic bit e = exp_q.pop_front();
            automatic int t = tag_q.pop_front();
            check(txd == e, $sformatf("R%0d bit", t), txd, e);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic push_bits(input logic [15:0] v, input int n, input int tag);
        for (int i = n - 1; i >= 0; i--) begin
            exp_q.push_back(v[i]);
            tag_q.push_back(tag);
        end
    endtask

    function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r = c;
        for (int i = 7; i >= 0; i--) begin
            if (r[15] ^ d[i]) r = (r << 1) ^ 16'h1021;
            else              r = r << 1;
        end
        return r;
    endfunction

    task automatic write_buf(input logic [7:0] d);
        @(negedge clk); wr_data = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic strobe(input int which);
        @(negedge clk);
        if (which == 0) cmd_rst_txip = 1'b1;
        if (which == 1) cmd_rst_eom  = 1'b1;
        if (which == 2) cmd_rst_crc  = 1'b1;
        @(negedge clk);
        cmd_rst_txip = 1'b0; cmd_rst_eom = 1'b0; cmd_rst_crc = 1'b0;
    endtask

    // Enable exactly on a tick cycle so the next edge starts the first slot.
    task automatic start_tx;
        do @(negedge clk); while (!bit_en);
        #1 tx_en = 1'b1;
    endtask

    task automatic wait_q(input int n);
        do begin @(negedge clk); #1; end while (exp_q.size() != n);
    endtask

    task automatic wait_rise(input int which);
        do @(negedge clk); while ((which == 0) ? !tx_irq : !ext_irq);
    endtask

    initial begin
        logic [15:0] crc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(txd == 1'b1, "R1 txd", txd, 1);
        check(buf_empty == 1'b1, "R1 buf_empty", buf_empty, 1);
        check(eom_latch == 1'b1, "R1 eom_latch", eom_latch, 1);
        check(tx_irq == 1'b0 && ext_irq == 1'b0, "R1 irqs", {tx_irq, ext_irq}, 0);
        check(tx_rdy == 1'b0, "R1 tx_rdy", tx_rdy, 0);

        // Message 1: check-sum fill; A counted, B excluded (R8).
        strobe(2); strobe(1);
        check(eom_latch == 1'b0, "R6 latch cleared", eom_latch, 0);
        crc_en = 1'b1;
        write_buf(8'hA5);
        check(buf_empty == 1'b0, "R3 write clears empty", buf_empty, 0);
        crc = crc_byte(16'hFFFF, 8'hA5);
        start_tx;
        push_bits(16'h00A5, 8, 2);
        wait_rise(0);
        check(buf_empty == 1'b1 && tx_rdy == 1'b1, "R3 empty+rdy after transfer", {buf_empty, tx_rdy}, 3);
        crc_en = 1'b0;
        write_buf(8'h3C);
        check(tx_irq == 1'b0 && tx_rdy == 1'b0, "R4 write clears irq, R3 rdy", {tx_irq, tx_rdy}, 0);
        push_bits(16'h003C, 8, 2);
        push_bits(crc, 16, 8);
        for (int k = 0; k < 3; k++) push_bits({8'h0, sync_char}, 8, 6);
        wait_rise(0);
        strobe(0);
        check(tx_irq == 1'b0, "R4 command clears irq", tx_irq, 0);
        wait_rise(1);
        check(eom_latch == 1'b1, "R6 latch set at crc", eom_latch, 1);
        check(buf_empty == 1'b0, "R7 empty low during crc", buf_empty, 0);
        wait_rise(0);
        check(buf_empty == 1'b1, "R7 empty after crc", buf_empty, 1);
        // R9: drop enable mid-sync, slot completes then mark.
        wait_q(4);
        tx_en = 1'b0;
        push_bits(16'hFFFF, 12, 9);
        wait_q(0);
        write_buf(8'h5E);
        push_bits(16'hFFFF, 8, 9);
        wait_q(0);
        check(buf_empty == 1'b0 && txd == 1'b1, "R9 buffer held while disabled", {buf_empty, txd}, 2);

        // Message 2: abort inside the check-sum slot (R10).
        crc_en = 1'b1;
        strobe(2); strobe(1);
        crc = crc_byte(16'hFFFF, 8'h5E);
        start_tx;
        push_bits(16'h005E, 8, 2);
        push_bits(crc, 16, 8);
        wait_q(10);
        tx_en = 1'b0;
        for (int k = 0; k < 10; k++) begin
            void'(exp_q.pop_back());
            void'(tag_q.pop_back());
        end
        for (int i = 6; i < 16; i++) begin
            exp_q.push_back(sync_char[7 - (i % 8)]);
            tag_q.push_back(10);
        end
        push_bits(16'hFFFF, 8, 10);
        wait_q(0);
        check(eom_latch == 1'b1, "R6 latch set again", eom_latch, 1);

        // Message 3: sync-only fill (R5).
        write_buf(8'hC3);
        start_tx;
        push_bits(16'h00C3, 8, 2);
        for (int k = 0; k < 2; k++) push_bits({8'h0, sync_char}, 8, 5);
        wait_rise(0);
        strobe(0);
        wait_rise(1);
        check(tx_irq == 1'b1, "R5 irq at first sync", tx_irq, 1);
        @(negedge clk);
        check(ext_irq == 1'b0, "R5 ext pulse one cycle", ext_irq, 0);
        wait_q(4);
        tx_en = 1'b0;
        push_bits(16'hFFFF, 8, 9);
        wait_q(0);
        check(txd == 1'b1, "R2 rest high", txd, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule